// File: doc/BRIEF.md
# Grouped Current-Sample Conversion Sequencer

This block controls a group conversion of motor-phase current inputs that are sampled at the same instant and then converted one at a time by a single external converter. A start strobe opens a group. Every selected channel tracks its input during one shared acquisition window. The channels are then handed to the converter in a fixed order, and each result is written to a register of its own. The host can read these registers in any order.

The V and W phases are converted in every group. Two control bits add the U phase and the auxiliary input, so a group holds two, three or four channels. When a group finishes, the block sets a done flag in the status register and, if enabled, raises an interrupt request. The request is either a short pulse or a level that stays high until the status register is read. A further control bit halves the rate of the sequencer's internal system clock, which is needed for fast input clocks. The converter is modelled as a request strobe with a channel select, followed by an 11-bit data word that is valid a fixed time later.

Top module: `conv_group_seq`

## Requirements
- R1: V and W are converted in every group. Control bit 0 adds U and control bit 1 adds AUX, so each group issues 2, 3 or 4 conversion requests. The channel set is captured when the group is accepted.
- R2: Requests are issued in the order V, W, U, AUX, and a disabled channel is skipped. The `conv_sel` codes are V=0, W=1, U=2, AUX=3. A request occurs only while a group is active.
- R3: After a start is accepted, `acq_track` is high for exactly 20 system cycles and no request is issued during that time. The first request follows in the cycle right after the window closes.
- R4: Each channel slot lasts 40 system cycles and `conv_req` is a single-cycle pulse. With an undivided clock, a group of 2, 3 or 4 channels ends 100, 140 or 180 cycles after the start edge.
- R5: The result registers sit at addresses V=0x5, W=0x6, AUX=0x7 and U=0x8. Each holds the 11-bit converter word shifted left by one, so bit 0 always reads 0. A read returns its data one clock after `rd_en`. All registers reset to 0.
- R6: Writes to the result addresses have no effect, and unused addresses such as 0x0 and 0xF read 0.
- R7: A start that arrives while a group is active is ignored. Status bit 1 reads 1 while a group is active.
- R8: Status (address 0xE) bit 0 is set when a group ends. A read of the status register returns the value held before the read and then clears this bit.
- R9: When control bit 3 is 1 and control bit 4 is 0, the end of a group drives `irq` high for exactly one system cycle.
- R10: When control bits 3 and 4 are both 1, `irq` goes high at the end of a group and stays high until the status register is read.
- R11: When control bit 3 is 0, `irq` stays low.
- R12: When control bit 2 is 1, the system cycle is two input clocks long. A four-channel group then ends 359 or 360 input cycles after the start edge, and an edge-mode pulse lasts 2 input cycles.
- R13: The control register at address 0xD holds bits 4:0 as written and reads 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Group start strobe |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 12 | Register write data |
| rdata | output | 12 | Register read data, valid one clock after `rd_en` |
| acq_track | output | 1 | High during the shared acquisition window |
| conv_req | output | 1 | Converter request pulse |
| conv_sel | output | 2 | Channel being converted |
| conv_data | input | 11 | Converter result word |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check on every cycle the rules that can be written as local properties:
- requests occur only inside an active group and outside the acquisition window;
- the first request follows the window directly, and each request is a single-cycle pulse;
- a group stays active until its final slot;
- the done flag follows the group's end;
- result reads always show bit 0 clear;
- an edge-mode request drops after one system cycle, and a level-mode request holds until the status register is read.

Only the bench scenarios can show the properties that span a whole group: the exact channel order for each channel set, the 100/140/180-cycle group lengths, the result values landing at the right addresses, the ignored start and writes, and the effect of the clock divider on group length and pulse width.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    CH_V   = 2'd0,
    CH_W   = 2'd1,
    CH_U   = 2'd2,
    CH_AUX = 2'd3
  } chan_e;

  typedef struct packed {
    logic  last;
    chan_e ch;
  } step_t;

  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned N_CHAN  = 4;
  localparam int unsigned CTRL_W  = 5;

  // control register fields
  localparam int unsigned CB_U     = 0;
  localparam int unsigned CB_AUX   = 1;
  localparam int unsigned CB_DIV2  = 2;
  localparam int unsigned CB_IRQEN = 3;
  localparam int unsigned CB_LEVEL = 4;

  localparam logic [ADDR_W-1:0] A_RES_V   = 4'h5;
  localparam logic [ADDR_W-1:0] A_RES_W   = 4'h6;
  localparam logic [ADDR_W-1:0] A_RES_AUX = 4'h7;
  localparam logic [ADDR_W-1:0] A_RES_U   = 4'h8;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'hD;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'hE;

  // next channel after cur in V,W,U,AUX order; last=1 when cur ends the group
  function automatic step_t next_step(input chan_e cur, input logic u_en, input logic aux_en);
    step_t s;
    s.last = 1'b0;
    s.ch   = cur;
    case (cur)
      CH_V: s.ch = CH_W;
      CH_W: begin
        if (u_en)        s.ch = CH_U;
        else if (aux_en) s.ch = CH_AUX;
        else             s.last = 1'b1;
      end
      CH_U: begin
        if (aux_en) s.ch = CH_AUX;
        else        s.last = 1'b1;
      end
      default: s.last = 1'b1;
    endcase
    return s;
  endfunction

  function automatic int unsigned group_size(input logic u_en, input logic aux_en);
    return 2 + int'(u_en) + int'(aux_en);
  endfunction

  function automatic int unsigned group_cycles(input int unsigned acq, input int unsigned conv,
                                               input int unsigned n);
    return acq + n * conv;
  endfunction

  function automatic logic res_hit(input logic [ADDR_W-1:0] a);
    return (a == A_RES_V) || (a == A_RES_W) || (a == A_RES_AUX) || (a == A_RES_U);
  endfunction

  function automatic chan_e res_chan(input logic [ADDR_W-1:0] a);
    chan_e c;
    case (a)
      A_RES_W:   c = CH_W;
      A_RES_AUX: c = CH_AUX;
      A_RES_U:   c = CH_U;
      default:   c = CH_V;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sys_tick_gen.sv
module sys_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic div2,
  output logic tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign tick = ~div2 | phase;
endmodule

// File: rtl/group_fsm.sv
module group_fsm
  import conv_seq_pkg::*;
#(
  parameter int unsigned ACQ_CYC  = 20,
  parameter int unsigned CONV_CYC = 40
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  start,
  input  logic  u_en,
  input  logic  aux_en,
  output logic  busy,
  output logic  acq_track,
  output logic  conv_req,
  output chan_e cur_ch,
  output logic  slot_end,
  output logic  grp_end
);
  localparam int unsigned CMAX = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int unsigned CW   = (CMAX > 1) ? $clog2(CMAX) : 1;
  localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYC - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV} state_e;

  state_e        st;
  logic [CW-1:0] cnt;
  chan_e         ch;
  logic          u_l, aux_l;
  logic          req_q;
  step_t         nxt;

  assign nxt      = next_step(ch, u_l, aux_l);
  assign slot_end = (st == S_CONV) && tick && (cnt == CONV_LAST);
  assign grp_end  = slot_end && nxt.last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      ch    <= CH_V;
      u_l   <= 1'b0;
      aux_l <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st    <= S_ACQ;
            cnt   <= '0;
            ch    <= CH_V;
            u_l   <= u_en;
            aux_l <= aux_en;
          end
        end
        S_ACQ: begin
          if (tick) begin
            if (cnt == ACQ_LAST) begin
              st    <= S_CONV;
              cnt   <= '0;
              req_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_CONV: begin
          if (tick) begin
            if (cnt == CONV_LAST) begin
              cnt <= '0;
              if (nxt.last) begin
                st <= S_IDLE;
              end else begin
                ch    <= nxt.ch;
                req_q <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign acq_track = (st == S_ACQ);
  assign conv_req  = req_q;
  assign cur_ch    = ch;
endmodule

// File: rtl/result_bank.sv
module result_bank
  import conv_seq_pkg::*;
#(
  parameter int unsigned ADC_W = 11,
  parameter int unsigned REG_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  chan_e                        wr_ch,
  input  logic [ADC_W-1:0]             din,
  output logic [N_CHAN-1:0][REG_W-1:0] res
);
  localparam int unsigned PAD = REG_W - ADC_W;

  function automatic logic [REG_W-1:0] align(input logic [ADC_W-1:0] d);
    return {d, {PAD{1'b0}}};
  endfunction

  for (genvar g = 0; g < N_CHAN; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n)                          res[g] <= '0;
      else if (wr && (int'(wr_ch) == g))   res[g] <= align(din);
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic grp_end,
  input  logic stat_rd,
  input  logic irq_en,
  input  logic level,
  output logic done,
  output logic irq
);
  logic pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      if (grp_end)      done <= 1'b1;
      else if (stat_rd) done <= 1'b0;
      if (grp_end)      pulse <= 1'b1;
      else if (tick)    pulse <= 1'b0;
    end
  end

  assign irq = irq_en & (level ? done : pulse);
endmodule

// File: rtl/conv_group_seq.sv
module conv_group_seq
  import conv_seq_pkg::*;
#(
  parameter int unsigned ACQ_CYC  = 20,
  parameter int unsigned CONV_CYC = 40,
  parameter int unsigned ADC_W    = 11,
  parameter int unsigned REG_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             acq_track,
  output logic             conv_req,
  output logic [1:0]       conv_sel,
  input  logic [ADC_W-1:0] conv_data,
  output logic             irq
);
  logic [CTRL_W-1:0]            ctrl;
  logic                         tick, busy, slot_end, grp_end, done, stat_rd;
  logic                         irq_en_w, level_w;
  chan_e                        cur_ch;
  logic [N_CHAN-1:0][REG_W-1:0] res;
  logic [REG_W-1:0]             rd_mux, rdata_q;
  logic                         unused_wdata_hi;

  assign irq_en_w        = ctrl[CB_IRQEN];
  assign level_w         = ctrl[CB_LEVEL];
  assign stat_rd         = rd_en && (addr == A_STAT);
  assign unused_wdata_hi = ^wdata[REG_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n)                          ctrl <= '0;
    else if (wr_en && (addr == A_CTRL))  ctrl <= wdata[CTRL_W-1:0];
  end

  sys_tick_gen u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .div2 (ctrl[CB_DIV2]),
    .tick (tick)
  );

  group_fsm #(.ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start    (start),
    .u_en     (ctrl[CB_U]),
    .aux_en   (ctrl[CB_AUX]),
    .busy     (busy),
    .acq_track(acq_track),
    .conv_req (conv_req),
    .cur_ch   (cur_ch),
    .slot_end (slot_end),
    .grp_end  (grp_end)
  );

  result_bank #(.ADC_W(ADC_W), .REG_W(REG_W)) u_res (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (slot_end),
    .wr_ch(cur_ch),
    .din  (conv_data),
    .res  (res)
  );

  irq_unit u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .grp_end(grp_end),
    .stat_rd(stat_rd),
    .irq_en (irq_en_w),
    .level  (level_w),
    .done   (done),
    .irq    (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (res_hit(addr))        rd_mux = res[res_chan(addr)];
    else if (addr == A_CTRL)  rd_mux = {{(REG_W-CTRL_W){1'b0}}, ctrl};
    else if (addr == A_STAT)  rd_mux = {{(REG_W-2){1'b0}}, busy, done};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign conv_sel = cur_ch;
endmodule

// File: rtl/conv_group_seq_chk.sv
module conv_group_seq_chk #(
  parameter int unsigned REG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             busy,
  input logic             acq_track,
  input logic             conv_req,
  input logic             grp_end,
  input logic             done,
  input logic             irq,
  input logic             irq_en,
  input logic             level,
  input logic             stat_rd,
  input logic             rd_en,
  input logic [3:0]       addr,
  input logic [REG_W-1:0] rdata
);
  p_req_in_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (busy && !acq_track));

  p_window_then_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(acq_track) && busy) |-> conv_req);

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  p_lsb_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 4'h5 || addr == 4'h6 || addr == 4'h7 || addr == 4'h8)) |=> (rdata[0] == 1'b0));

  p_stay_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !grp_end) |=> busy);

  p_done_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> done);

  p_edge_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !level && tick && !grp_end) |=> !irq);

  p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && level && irq_en && !stat_rd) |=> irq);
endmodule

bind conv_group_seq conv_group_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .busy     (busy),
  .acq_track(acq_track),
  .conv_req (conv_req),
  .grp_end  (grp_end),
  .done     (done),
  .irq      (irq),
  .irq_en   (irq_en_w),
  .level    (level_w),
  .stat_rd  (stat_rd),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata)
);

// File: tb/test_conv_group_seq.sv
module test_conv_group_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [11:0] wdata = 12'h0;
  logic [11:0] rdata;
  logic        acq_track, conv_req, irq;
  logic [1:0]  conv_sel;
  logic [10:0] conv_data = 11'h0;

  conv_group_seq i_conv_group_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .acq_track(acq_track),
    .conv_req(conv_req), .conv_sel(conv_sel), .conv_data(conv_data), .irq(irq)
  );

  always #10 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  logic [4:0]  cur_ctrl = 5'h0;
  logic [10:0] val [4];
  logic [11:0] exp_res [4];
  int          got_q[$];
  bit          model_on = 1'b1;
  bit          irq_seen = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      summary();
      $finish;
    end
  end

  // converter model: fixed latency, garbage until then
  int lat = 0;
  logic [1:0] pend = 2'd0;
  always @(posedge clk) begin
    if (conv_req) begin
      lat = 6; pend = conv_sel; conv_data <= 11'h2AA;
    end else if (lat > 0) begin
      lat--;
      if (lat == 0) conv_data <= val[pend];
    end
  end

  // reference model
  bit m_busy = 0, m_done = 0, m_pulse = 0;
  int t = 0, m_T = 0;
  int ch_q[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pulse = 0; t = 0;
    end else begin
      m_pulse = 0;
      if (m_busy) begin
        t++;
        if (t == m_T) begin m_busy = 0; m_pulse = 1; m_done = 1; end
      end else if (start) begin
        ch_q = {0, 1};
        if (cur_ctrl[0]) ch_q.push_back(2);
        if (cur_ctrl[1]) ch_q.push_back(3);
        m_T = 20 + 40 * ch_q.size();
        m_busy = 1; t = 0;
      end
      if (rd_en && addr == 4'hE && !m_pulse) m_done = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_seen = 1'b1;
      if (conv_req) got_q.push_back(int'(conv_sel));
      if (model_on) begin
        bit e_trk, e_req, e_irq;
        e_trk = m_busy && t < 20;
        e_req = m_busy && t >= 20 && ((t - 20) % 40 == 0);
        e_irq = cur_ctrl[3] && (cur_ctrl[4] ? m_done : m_pulse);
        chk(acq_track == e_trk, "R3 acq_track", acq_track, e_trk);
        chk(conv_req == e_req, "R4 conv_req timing", conv_req, e_req);
        if (e_req) chk(int'(conv_sel) == ch_q[(t - 20) / 40], "R2 conv_sel", conv_sel, ch_q[(t - 20) / 40]);
        chk(irq == e_irq, "R9/R10/R11 irq", irq, e_irq);
      end
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    if (a == 4'hD) cur_ctrl = d[4:0];
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [11:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  // start and count edges until irq is seen high
  task automatic start_to_irq(output int n);
    @(negedge clk); start = 1;
    @(posedge clk); n = 0;
    @(negedge clk); start = 0;
    while (!irq && n < 1000) begin @(posedge clk); n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (m_busy && g < 2000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_order(input string req);
    chk(got_q.size() == ch_q.size(), {req, " request count"}, got_q.size(), ch_q.size());
    foreach (got_q[i]) if (i < ch_q.size())
      chk(got_q[i] == ch_q[i], {req, " order"}, got_q[i], ch_q[i]);
    foreach (ch_q[i]) exp_res[ch_q[i]] = {val[ch_q[i]], 1'b0};
  endtask

  task automatic check_results(input string req);
    logic [11:0] d;
    logic [3:0] adr [4] = '{4'h5, 4'h6, 4'h8, 4'h7};
    for (int c = 0; c < 4; c++) begin
      reg_rd(adr[c], d);
      chk(d == exp_res[c], req, d, exp_res[c]);
      chk(d[0] == 1'b0, "R5 bit0", d[0], 0);
    end
  endtask

  initial begin
    logic [11:0] d;
    int n, w;
    for (int c = 0; c < 4; c++) exp_res[c] = 12'h0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(irq == 0 && acq_track == 0 && conv_req == 0, "R8 reset outputs", {irq, acq_track, conv_req}, 0);
    reg_rd(4'hD, d); chk(d == 0, "R13 reset ctrl", d, 0);
    reg_rd(4'hE, d); chk(d == 0, "R8 reset status", d, 0);
    reg_rd(4'h5, d); chk(d == 0, "R5 reset result", d, 0);

    // S1: two channels, edge irq
    val = '{11'h123, 11'h7FF, 11'h400, 11'h055};
    reg_wr(4'hD, 12'h008);
    got_q = {};
    start_to_irq(n);
    chk(n == 100, "R4 two-channel length", n, 100);
    w = 0;
    while (irq && w < 10) begin w++; @(negedge clk); end
    chk(w == 1, "R9 pulse width", w, 1);
    wait_idle();
    check_order("R1 two channels");
    check_results("R1 R5 two-channel results");
    reg_rd(4'hE, d); chk(d == 12'h001, "R8 done read", d, 1);
    reg_rd(4'hE, d); chk(d == 12'h000, "R8 done cleared", d, 0);

    // S2: three channels, level irq, ignored start
    val = '{11'h0F0, 11'h501, 11'h3C3, 11'h1AB};
    reg_wr(4'hD, 12'h019);
    got_q = {};
    pulse_start();
    repeat (48) @(negedge clk);
    pulse_start();
    reg_rd(4'hE, d); chk(d == 12'h002, "R7 busy bit", d, 2);
    wait_idle();
    chk(got_q.size() == 3, "R7 second start ignored", got_q.size(), 3);
    check_order("R2 three channels");
    repeat (10) @(negedge clk);
    chk(irq == 1, "R10 level held", irq, 1);
    reg_rd(4'hE, d); chk(d == 12'h001, "R10 status read", d, 1);
    chk(irq == 0, "R10 cleared by status read", irq, 0);
    check_results("R5 three-channel results");

    // S3: four channels, irq disabled
    val = '{11'h001, 11'h6A5, 11'h2B7, 11'h7FE};
    reg_wr(4'hD, 12'h003);
    got_q = {}; irq_seen = 0;
    pulse_start();
    wait_idle();
    repeat (5) @(negedge clk);
    chk(irq_seen == 0, "R11 irq disabled", irq_seen, 0);
    check_order("R1 R2 four channels");
    check_results("R5 four-channel results");

    // S4: read-only results, unused addresses, ctrl readback
    reg_wr(4'h5, 12'hFFF);
    reg_rd(4'h5, d); chk(d == exp_res[0], "R6 write to result ignored", d, exp_res[0]);
    reg_rd(4'h0, d); chk(d == 0, "R6 unused 0x0", d, 0);
    reg_rd(4'hF, d); chk(d == 0, "R6 unused 0xF", d, 0);
    reg_wr(4'hD, 12'hFE3);
    reg_rd(4'hD, d); chk(d == 12'h003, "R13 ctrl readback", d, 3);
    reg_rd(4'hE, d);

    // S5: divided clock
    model_on = 0;
    val = '{11'h111, 11'h222, 11'h333, 11'h444};
    reg_wr(4'hD, 12'h00F);
    got_q = {};
    start_to_irq(n);
    chk(n == 359 || n == 360, "R12 divided length", n, 360);
    w = 0;
    while (irq && w < 10) begin w++; @(negedge clk); end
    chk(w == 2, "R12 divided pulse width", w, 2);
    repeat (5) @(negedge clk);
    chk(got_q.size() == 4, "R12 divided request count", got_q.size(), 4);
    foreach (got_q[i]) chk(got_q[i] == i, "R2 divided order", got_q[i], i);
    for (int c = 0; c < 4; c++) exp_res[c] = {val[c], 1'b0};
    check_results("R12 divided results");
    reg_rd(4'hE, d); chk(d == 12'h001, "R8 divided done", d, 1);

    summary();
    $finish;
  end
endmodule